// File: doc/BRIEF.md
# Identifier-Keyed Channel Hop Sequencer

This block turns a 24-bit transmitter identifier into a private list of sixteen RF channel numbers. It then hands out one channel per outgoing packet. An 8-bit selector is formed by adding the three identifier bytes. The selector picks one of four rows in a built-in 4x16 base table and also yields a small offset. That offset is added to every entry of the chosen row. Any result whose low nibble is zero is moved down by three.

A load strobe captures the identifier and starts the build. The build writes one list entry per clock for sixteen clocks and then raises a ready flag. After that, each next-packet strobe advances a 5-bit hop index. The channel output always shows the list entry selected by the index with its lowest bit dropped, so every channel serves two consecutive packets. When the index rolls over from 31 to 0, a single-cycle wrap pulse is produced, which a radio driver can use to refresh its power level.

Top module: `hop_seq`

## Requirements
- R1: The selector is the three identifier bytes added modulo 256; selector bits [1:0] choose the base row (row 0 starts 0x27, 0x1B, 0x39, 0x28; row 1 starts 0x2E, 0x33, 0x25, 0x38).
- R2: Every entry of the chosen row gets the offset (selector AND 0x1E) shifted right by 2 added to it, modulo 256.
- R3: A channel whose low nibble is zero after the offset is stored as that value minus 3; any other value is stored unchanged.
- R4: A load strobe clears ready_o on the next edge; ready_o then rises on the 16th rising edge after the edge that sampled the load strobe.
- R5: chan_o shows list entry (hop index >> 1); each accepted next-packet strobe adds one to the index, so each entry appears for two consecutive packets.
- R6: The hop index counts modulo 32; the strobe that moves it from 31 to 0 makes wrap_o high for exactly the following cycle, and wrap_o is low otherwise.
- R7: A next-packet strobe while ready_o is low leaves the hop index unchanged.
- R8: After reset, ready_o, wrap_o and chan_o are 0. A load strobe returns the hop index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture identifier and rebuild the list |
| id_lo_i | input | 8 | Identifier byte 0 |
| id_mid_i | input | 8 | Identifier byte 1 |
| id_hi_i | input | 8 | Identifier byte 2 |
| next_i | input | 1 | One packet is being sent; advance the hop index |
| ready_o | output | 1 | List is complete and the index may advance |
| chan_o | output | 8 | Channel for the current packet |
| wrap_o | output | 1 | One-cycle pulse after the index rolls over to 0 |

## Verification
On every cycle the assertions check these rules: a single index step per accepted strobe, a frozen index while the list is not ready, wrap pulses only at index zero, the clearing effect of a load, ready following the last build write, and the absence of zero low nibbles in stored channels. The actual channel values can only be shown by the bench's scenarios. These include the row choice, the offset and the remap for specific identifiers, as well as the exact sixteen-edge build latency and the two-packets-per-channel walk across a full 32-packet cycle.

// File: rtl/hopseq_pkg.sv
// hopseq_pkg: shared widths, the base channel table and the channel
// derivation rule used by the hop sequencer.
// Assumes: four rows of sixteen 8-bit base channels, all >= 0x10.
package hopseq_pkg;
    localparam int CH_W   = 8;
    localparam int ROWS   = 4;
    localparam int COLS   = 16;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int IDX_W  = COL_W + 1;

    typedef logic [CH_W-1:0] chan_t;

    localparam chan_t BASE_TBL [ROWS][COLS] = '{
        '{8'h27, 8'h1B, 8'h39, 8'h28, 8'h24, 8'h22, 8'h2E, 8'h36,
          8'h19, 8'h21, 8'h29, 8'h14, 8'h1E, 8'h12, 8'h2D, 8'h18},
        '{8'h2E, 8'h33, 8'h25, 8'h38, 8'h19, 8'h12, 8'h18, 8'h16,
          8'h2A, 8'h1C, 8'h1F, 8'h37, 8'h2F, 8'h23, 8'h34, 8'h10},
        '{8'h11, 8'h1A, 8'h35, 8'h24, 8'h28, 8'h18, 8'h25, 8'h2A,
          8'h32, 8'h2C, 8'h14, 8'h27, 8'h36, 8'h34, 8'h1C, 8'h17},
        '{8'h22, 8'h27, 8'h17, 8'h39, 8'h34, 8'h28, 8'h2B, 8'h1D,
          8'h18, 8'h2A, 8'h21, 8'h38, 8'h10, 8'h26, 8'h20, 8'h1F}
    };

    // Offset from the selector, add with wrap, pull zero-nibble values down by 3.
    function automatic chan_t derive_chan(input chan_t base, input chan_t sel);
        chan_t off;
        chan_t v;
        off = (sel & 8'h1E) >> 2;
        v   = base + off;
        return (v[3:0] == 4'd0) ? (v - 8'd3) : v;
    endfunction
endpackage

// File: rtl/hopseq_base_rom.sv
// hopseq_base_rom: combinational lookup of one base channel by row and column.
// Assumes: row/col within the table bounds defined in hopseq_pkg.
module hopseq_base_rom
    import hopseq_pkg::*;
(
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    output chan_t            base_o
);
    // Purpose: index the constant table.
    always_comb begin
        base_o = BASE_TBL[row_i][col_i];
    end
endmodule

// File: rtl/hopseq_list_builder.sv
// hopseq_list_builder: on a load strobe, latches the identifier sum and
// writes one derived channel per cycle into a COLS-entry list, then
// raises ready. A new load restarts the build at any time.
// Assumes: base_i is the table entry for (row_o, col_o) in the same cycle.
module hopseq_list_builder
    import hopseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  chan_t            id0_i,
    input  chan_t            id1_i,
    input  chan_t            id2_i,
    input  chan_t            base_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output chan_t            list_o [COLS],
    output logic             ready_o
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    chan_t            sel_q;
    logic             busy_q;
    logic [COL_W-1:0] cnt_q;
    chan_t            id_sum;

    assign id_sum = id0_i + id1_i + id2_i;
    assign row_o  = sel_q[ROW_W-1:0];
    assign col_o  = cnt_q;

    // Purpose: capture the selector on load, then fill one entry per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            ready_o <= 1'b0;
            for (int i = 0; i < COLS; i++) list_o[i] <= '0;
        end else if (load_i) begin
            sel_q   <= id_sum;
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            ready_o <= 1'b0;
        end else if (busy_q) begin
            list_o[cnt_q] <= derive_chan(base_i, sel_q);
            cnt_q         <= cnt_q + 1'b1;
            if (cnt_q == LAST_COL) begin
                busy_q  <= 1'b0;
                ready_o <= 1'b1;
            end
        end
    end

    // R4: the final build write is followed by ready.
    a_r4_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !load_i && cnt_q == LAST_COL |=> ready_o);
    // R4: a load always withdraws ready on the next edge.
    a_r4_load_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !ready_o && busy_q);
    // R3: every written entry has a non-zero low nibble.
    a_r3_no_zero_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !load_i |=> list_o[$past(cnt_q)][3:0] != 4'd0);
endmodule

// File: rtl/hopseq_index_ctr.sv
// hopseq_index_ctr: 5-bit packet hop index with a one-cycle wrap pulse
// when it rolls from its maximum back to zero.
// Assumes: clear_i has priority over adv_i.
module hopseq_index_ctr
    import hopseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             wrap_o
);
    // Purpose: count packets modulo 2**IDX_W and flag each rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o  <= '0;
            wrap_o <= 1'b0;
        end else begin
            wrap_o <= 1'b0;
            if (clear_i) begin
                idx_o <= '0;
            end else if (adv_i) begin
                idx_o <= idx_o + 1'b1;
                if (idx_o == '1) wrap_o <= 1'b1;
            end
        end
    end

    // R5: one step per accepted advance.
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !clear_i |=> idx_o == IDX_W'($past(idx_o) + 1'b1));
    // R6: a wrap pulse is only ever seen with the index at zero.
    a_r6_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> idx_o == '0);
    // R6: the pulse lasts one cycle at most.
    a_r6_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);
    // R8: clear returns the index to zero without a pulse.
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> idx_o == '0 && !wrap_o);
endmodule

// File: rtl/hop_seq.sv
// hop_seq: identifier-keyed channel hop sequencer. Builds a channel list
// from the identifier, then outputs list[index >> 1] per packet.
// Assumes: next_i is a one-cycle strobe per packet.
module hop_seq
    import hopseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] id_lo_i,
    input  logic [7:0] id_mid_i,
    input  logic [7:0] id_hi_i,
    input  logic       next_i,
    output logic       ready_o,
    output logic [7:0] chan_o,
    output logic       wrap_o
);
    logic [ROW_W-1:0] rom_row;
    logic [COL_W-1:0] rom_col;
    chan_t            rom_base;
    chan_t            list [COLS];
    logic [IDX_W-1:0] idx;
    logic             adv;

    hopseq_base_rom u_rom (
        .row_i  (rom_row),
        .col_i  (rom_col),
        .base_o (rom_base)
    );

    hopseq_list_builder u_build (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .id0_i   (id_lo_i),
        .id1_i   (id_mid_i),
        .id2_i   (id_hi_i),
        .base_i  (rom_base),
        .row_o   (rom_row),
        .col_o   (rom_col),
        .list_o  (list),
        .ready_o (ready_o)
    );

    // Purpose: only advance on a strobe once the list is complete.
    assign adv = next_i & ready_o & ~load_i;

    hopseq_index_ctr u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .adv_i   (adv),
        .idx_o   (idx),
        .wrap_o  (wrap_o)
    );

    // Purpose: each list entry serves two consecutive packets.
    assign chan_o = list[idx[IDX_W-1:1]];

    // R7: with the list not ready and no load, the index is frozen.
    a_r7_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o && !load_i |=> $stable(idx));
endmodule

// File: tb/hop_seq_bench.sv
`timescale 1ns/1ps
module hop_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] id_lo_i = '0, id_mid_i = '0, id_hi_i = '0;
    logic       next_i = 1'b0;
    logic       ready_o, wrap_o;
    logic [7:0] chan_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    hop_seq u_hop_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .id_lo_i(id_lo_i), .id_mid_i(id_mid_i), .id_hi_i(id_hi_i),
        .next_i(next_i), .ready_o(ready_o), .chan_o(chan_o), .wrap_o(wrap_o)
    );

    localparam logic [7:0] TBL [4][16] = '{
        '{8'h27, 8'h1B, 8'h39, 8'h28, 8'h24, 8'h22, 8'h2E, 8'h36,
          8'h19, 8'h21, 8'h29, 8'h14, 8'h1E, 8'h12, 8'h2D, 8'h18},
        '{8'h2E, 8'h33, 8'h25, 8'h38, 8'h19, 8'h12, 8'h18, 8'h16,
          8'h2A, 8'h1C, 8'h1F, 8'h37, 8'h2F, 8'h23, 8'h34, 8'h10},
        '{8'h11, 8'h1A, 8'h35, 8'h24, 8'h28, 8'h18, 8'h25, 8'h2A,
          8'h32, 8'h2C, 8'h14, 8'h27, 8'h36, 8'h34, 8'h1C, 8'h17},
        '{8'h22, 8'h27, 8'h17, 8'h39, 8'h34, 8'h28, 8'h2B, 8'h1D,
          8'h18, 8'h2A, 8'h21, 8'h38, 8'h10, 8'h26, 8'h20, 8'h1F}
    };

    // Identifier vectors: rows 0..3, offsets 0 and 7, sums that wrap past 255.
    localparam int NV = 7;
    localparam logic [23:0] IDS [NV] = '{
        24'h000000, 24'h123456, 24'hFFFFFF, 24'h0A0B0C,
        24'h020000, 24'h0F0F00, 24'h010101
    };

    function automatic logic [7:0] exp_chan(logic [23:0] id, int e);
        logic [7:0] s, off, v;
        s   = id[7:0] + id[15:8] + id[23:16];           // R1
        off = (s & 8'h1E) >> 2;                          // R2
        v   = TBL[s[1:0]][e] + off;
        return (v[3:0] == 4'd0) ? v - 8'd3 : v;          // R3
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_load(input logic [23:0] id);
        {id_hi_i, id_mid_i, id_lo_i} = id;
        load_i = 1'b1;
        step();
        load_i = 1'b0;
    endtask

    task automatic pulse_next();
        next_i = 1'b1;
        step();
        next_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(); step();
        // R8: reset state
        chk("R8 ready after reset", ready_o, 0);
        chk("R8 wrap after reset", wrap_o, 0);
        chk("R8 chan after reset", chan_o, 0);
        rst_n = 1'b1;
        step();
        // R7: strobe with no list at all
        pulse_next();
        chk("R7 no ready without load", ready_o, 0);
        chk("R7 no wrap without load", wrap_o, 0);

        // Vector walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            do_load(IDS[v]);
            chk("R4 ready cleared by load", ready_o, 0);
            for (int k = 1; k <= 16; k++) begin
                step();
                if (k == 15) chk("R4 ready not yet at edge 15", ready_o, 0);
                if (k == 16) chk("R4 ready at edge 16", ready_o, 1);
            end
            for (int p = 0; p < 32; p++) begin
                chk("R1 R2 R3 R5 channel", chan_o, exp_chan(IDS[v], p >> 1));
                if (p > 0) chk("R6 no early wrap", wrap_o, 0);
                pulse_next();
            end
            chk("R6 wrap pulse", wrap_o, 1);
            chk("R6 index back to entry 0", chan_o, exp_chan(IDS[v], 0));
            step();
            chk("R6 wrap one cycle", wrap_o, 0);
        end

        // R7: strobes during the build are ignored
        do_load(24'h123456);
        step(); step();
        pulse_next(); pulse_next(); pulse_next();
        while (!ready_o) step();
        chk("R7 index frozen during build", chan_o, exp_chan(24'h123456, 0));
        pulse_next();
        chk("R7 second packet same entry", chan_o, exp_chan(24'h123456, 0));
        pulse_next();
        chk("R5 third packet next entry", chan_o, exp_chan(24'h123456, 1));

        // R8: reload mid-sequence resets the index
        for (int i = 0; i < 5; i++) pulse_next();
        chk("R5 mid-sequence entry", chan_o, exp_chan(24'h123456, 3));
        do_load(24'h0A0B0C);
        while (!ready_o) step();
        chk("R8 reload restarts at entry 0", chan_o, exp_chan(24'h0A0B0C, 0));
        chk("R8 no wrap on reload", wrap_o, 0);

        finish_run();
    end
endmodule